// File: doc/BRIEF.md
# Token-Ring Dual-Clock FIFO

This block moves data words from one synchronous clock domain to another whose clock is unrelated. Storage is a ring of identical cells. Each cell holds one word and a two-state status, FREE or HELD. A one-hot write token circulates the ring in the writer's domain, and a one-hot read token circulates it in the reader's domain. The cell under the write token is the only one that takes the incoming word. The cell under the read token is the only one that drives the output bus.

Each cell's status is split into two flip bits. The writer owns one of them and inverts it on every store into that cell. The reader owns the other and inverts it on every removal. A cell is HELD when the two bits differ and FREE when they match. There are two transitions: a store moves a cell from FREE to HELD, and a removal moves it from HELD to FREE.

Each side copies the other side's flip bits through two-flop synchronizers clocked by its own clock. A detector on each side then checks the status of every cell. The full flag is raised when no cell is FREE in the writer's view. The empty flag is raised when no cell is HELD in the reader's view. A store happens on a write-clock edge when a write is requested and the FIFO is not full. A removal happens on a read-clock edge when a read is requested and the FIFO is not empty. The read bus shows the head word ahead of the request, and the valid output is always high.

Top module: `tokfifo_ring`

## Requirements
- R1: After both resets, `put_full` is 0, `get_empty` is 1 and `get_data` is all zeros.
- R2: The FIFO holds exactly DEPTH words. `put_full` rises right after the write-clock edge that stores into the last FREE cell. It is 0 before that edge.
- R3: A write request while `put_full` is 1 stores nothing. A later drain returns exactly the DEPTH words that were accepted, and then reports empty.
- R4: A read request while `get_empty` is 1 removes nothing. `get_empty` stays 1, and the first word written afterwards is the first word read.
- R5: Words leave in the order they were accepted. While `get_empty` is 0, `get_data` shows the oldest stored word.
- R6: After a store into an empty FIFO, `get_empty` falls within 3 read-clock edges.
- R7: After a removal from a full FIFO, `put_full` falls within 3 write-clock edges.
- R8: `get_valid` is 1 at all times.
- R9: With both sides requesting in irregular patterns under several clock ratios, no accepted word is lost, duplicated or altered. The number of stored words never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_put | input | 1 | Write-side clock |
| rst_put_n | input | 1 | Write-side asynchronous reset, active low |
| put_req | input | 1 | Write request |
| put_data | input | WIDTH | Word to store |
| put_full | output | 1 | No FREE cell in the writer's view |
| clk_get | input | 1 | Read-side clock |
| rst_get_n | input | 1 | Read-side asynchronous reset, active low |
| get_req | input | 1 | Read request |
| get_data | output | WIDTH | Word in the cell under the read token |
| get_valid | output | 1 | Always 1 |
| get_empty | output | 1 | No HELD cell in the reader's view |

## Verification
The bench builds the block with DEPTH=4 and WIDTH=8. With only four cells, every fill level, the wrap of both tokens and the full-to-empty swing can be reached in a few dozen edges. It sweeps the read clock's half period over 3, 4, 7 and 13 ns against a fixed 4 ns write half period. This puts the reader in turn faster than, equal to and slower than the writer, so both synchronizer paths are tested at several phase relationships. For each ratio it fills the FIFO, drains it and streams 200 words.

// File: rtl/tokfifo_pkg.sv
package tokfifo_pkg;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_t;

    // A cell is HELD when the writer's and the reader's flip bits differ.
    function automatic slot_t slot_of(input logic wr_flip, input logic rd_flip);
        return (wr_flip ^ rd_flip) ? SLOT_HELD : SLOT_FREE;
    endfunction

endpackage

// File: rtl/tokfifo_sync.sv
module tokfifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/tokfifo_put_ctrl.sv
module tokfifo_put_ctrl
    import tokfifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic [WIDTH-1:0]             data,
    input  logic [DEPTH-1:0]             far_flip,
    output logic [DEPTH-1:0]             own_flip,
    output logic [DEPTH-1:0][WIDTH-1:0]  cells,
    output logic                         full
);
    localparam logic [DEPTH-1:0] TOK_HOME = DEPTH'(1);

    logic [DEPTH-1:0] tok;
    logic [DEPTH-1:0] held;
    slot_t            view [DEPTH];
    logic             put_en;

    for (genvar i = 0; i < DEPTH; i++) begin : g_view
        assign view[i] = slot_of(own_flip[i], far_flip[i]);
    end

    // Full detector: inspects every cell.
    always_comb begin
        held = '0;
        for (int i = 0; i < DEPTH; i++) begin
            unique case (view[i])
                SLOT_HELD: held[i] = 1'b1;
                SLOT_FREE: held[i] = 1'b0;
            endcase
        end
        full   = &held;
        put_en = req & ~full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok      <= TOK_HOME;
            own_flip <= '0;
        end else if (put_en) begin
            tok      <= {tok[DEPTH-2:0], tok[DEPTH-1]};
            own_flip <= own_flip ^ tok;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[i] <= '0;
            else if (put_en && tok[i])
                cells[i] <= data;
        end
    end

    // R2
    put_blocked_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> ($stable(tok) && $stable(own_flip)));

    // R9
    put_token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tok) == 1);

    // R2
    full_matches_token_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full == |(held & tok));

    // R9
    one_store_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(own_flip ^ $past(own_flip)) <= 1);
endmodule

// File: rtl/tokfifo_get_ctrl.sv
module tokfifo_get_ctrl
    import tokfifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic [DEPTH-1:0]             far_flip,
    input  logic [DEPTH-1:0][WIDTH-1:0]  cells,
    output logic [DEPTH-1:0]             own_flip,
    output logic [WIDTH-1:0]             data,
    output logic                         empty
);
    localparam logic [DEPTH-1:0] TOK_HOME = DEPTH'(1);

    logic [DEPTH-1:0] tok;
    logic [DEPTH-1:0] held;
    slot_t            view [DEPTH];
    logic             get_en;

    for (genvar i = 0; i < DEPTH; i++) begin : g_view
        assign view[i] = slot_of(far_flip[i], own_flip[i]);
    end

    // Empty detector and head-word selection.
    always_comb begin
        held = '0;
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            unique case (view[i])
                SLOT_HELD: held[i] = 1'b1;
                SLOT_FREE: held[i] = 1'b0;
            endcase
            if (tok[i])
                data = data | cells[i];
        end
        empty  = ~|held;
        get_en = req & ~empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok      <= TOK_HOME;
            own_flip <= '0;
        end else if (get_en) begin
            tok      <= {tok[DEPTH-2:0], tok[DEPTH-1]};
            own_flip <= own_flip ^ tok;
        end
    end

    // R4
    get_blocked_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> ($stable(tok) && $stable(own_flip)));

    // R5
    get_token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tok) == 1);

    // R5
    empty_matches_token_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == !(|(held & tok)));
endmodule

// File: rtl/tokfifo_ring.sv
module tokfifo_ring #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk_put,
    input  logic             rst_put_n,
    input  logic             put_req,
    input  logic [WIDTH-1:0] put_data,
    output logic             put_full,
    input  logic             clk_get,
    input  logic             rst_get_n,
    input  logic             get_req,
    output logic [WIDTH-1:0] get_data,
    output logic             get_valid,
    output logic             get_empty
);
    logic [DEPTH-1:0]            put_flip, put_flip_s;
    logic [DEPTH-1:0]            get_flip, get_flip_s;
    logic [DEPTH-1:0][WIDTH-1:0] cells;

    assign get_valid = 1'b1;

    tokfifo_put_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_put (
        .clk      (clk_put),
        .rst_n    (rst_put_n),
        .req      (put_req),
        .data     (put_data),
        .far_flip (get_flip_s),
        .own_flip (put_flip),
        .cells    (cells),
        .full     (put_full)
    );

    tokfifo_sync #(.W(DEPTH)) u_sync_to_get (
        .clk   (clk_get),
        .rst_n (rst_get_n),
        .d     (put_flip),
        .q     (put_flip_s)
    );

    tokfifo_sync #(.W(DEPTH)) u_sync_to_put (
        .clk   (clk_put),
        .rst_n (rst_put_n),
        .d     (get_flip),
        .q     (get_flip_s)
    );

    tokfifo_get_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_get (
        .clk      (clk_get),
        .rst_n    (rst_get_n),
        .req      (get_req),
        .far_flip (put_flip_s),
        .cells    (cells),
        .own_flip (get_flip),
        .data     (get_data),
        .empty    (get_empty)
    );
endmodule

// File: tb/tb_tokfifo_ring.sv
`timescale 1ns/1ps
module tb_tokfifo_ring;
    localparam int DEPTH = 4;
    localparam int WIDTH = 8;
    localparam int NW    = 200;

    logic             clk_put = 1'b0, clk_get = 1'b0;
    logic             rst_put_n = 1'b0, rst_get_n = 1'b0;
    logic             put_req = 1'b0, get_req = 1'b0;
    logic [WIDTH-1:0] put_data = '0;
    logic [WIDTH-1:0] get_data;
    logic             put_full, get_empty, get_valid;

    int gh = 5;
    int checks = 0, errors = 0;
    logic [WIDTH-1:0] model [0:1023];
    int wr_i, rd_i;

    always #4 clk_put = ~clk_put;
    always #(gh) clk_get = ~clk_get;

    tokfifo_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk_put, .rst_put_n, .put_req, .put_data, .put_full,
        .clk_get, .rst_get_n, .get_req, .get_data, .get_valid, .get_empty
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        put_req = 0; get_req = 0;
        rst_put_n = 0; rst_get_n = 0;
        repeat (3) @(negedge clk_get);
        repeat (3) @(negedge clk_put);
        rst_put_n = 1;
        @(negedge clk_get);
        rst_get_n = 1;
        repeat (2) @(negedge clk_get);
        @(negedge clk_put);
    endtask

    task automatic put_word(input logic [WIDTH-1:0] v, output bit taken);
        @(negedge clk_put);
        taken = !put_full;
        put_req = 1; put_data = v;
        @(negedge clk_put);
        put_req = 0;
    endtask

    task automatic get_word(output logic [WIDTH-1:0] v);
        int guard = 0;
        @(negedge clk_get);
        while (get_empty && guard < 20) begin
            @(negedge clk_get);
            guard++;
        end
        v = get_data;
        get_req = 1;
        @(negedge clk_get);
        get_req = 0;
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(negedge clk_get) begin
        if (rst_get_n) begin
            checks++;
            if (get_valid !== 1'b1) begin
                errors++;
                $display("FAIL R8: actual=%0d expected=%0d", get_valid, 1);
            end
        end
    end

    initial begin
        int halves [4] = '{3, 4, 7, 13};
        foreach (halves[h]) begin
            bit taken;
            int cnt;
            logic [WIDTH-1:0] v;
            logic [WIDTH-1:0] base;
            gh = halves[h];
            base = WIDTH'(8'h10 * (h + 1));
            do_reset();

            // R1
            chk(put_full == 0, "R1 full", put_full, 0);
            chk(get_empty == 1, "R1 empty", get_empty, 1);
            chk(get_data == 0, "R1 data", get_data, 0);

            // R4: reads while empty do nothing
            @(negedge clk_get); get_req = 1;
            repeat (5) @(negedge clk_get);
            get_req = 0;
            chk(get_empty == 1, "R4 empty held", get_empty, 1);

            // R6: first store, count read edges until not empty
            put_word(base, taken);
            chk(taken, "R2 first accepted", taken, 1);
            cnt = 0;
            while (get_empty && cnt < 10) begin
                @(posedge clk_get); cnt++; #1;
            end
            chk(cnt >= 1 && cnt <= 3, "R6 empty latency", cnt, 3);
            chk(get_data == base, "R4 first word after empty reads", get_data, base);

            // R2: fill remaining cells
            for (int k = 1; k < DEPTH; k++) begin
                chk(put_full == 0, "R2 not full early", put_full, 0);
                put_word(base + WIDTH'(k), taken);
                chk(taken, "R2 accepted", taken, 1);
            end
            chk(put_full == 1, "R2 full after DEPTH", put_full, 1);

            // R3: write while full is dropped
            put_word(8'hEE, taken);
            chk(!taken, "R3 rejected", taken, 0);
            chk(put_full == 1, "R3 still full", put_full, 1);

            // R7 and R5: first removal from full
            get_word(v);
            chk(v == base, "R5 order", v, base);
            cnt = 0;
            while (put_full && cnt < 10) begin
                @(posedge clk_put); cnt++; #1;
            end
            chk(cnt >= 1 && cnt <= 3, "R7 full latency", cnt, 3);

            for (int k = 1; k < DEPTH; k++) begin
                get_word(v);
                chk(v == base + WIDTH'(k), "R5 order", v, base + WIDTH'(k));
            end
            repeat (6) @(negedge clk_get);
            chk(get_empty == 1, "R3 nothing extra stored", get_empty, 1);

            // R9: streaming with irregular requests
            wr_i = 0; rd_i = 0;
            fork
                begin
                    logic [15:0] lf = 16'hACE1 ^ 16'(gh);
                    while (wr_i < NW) begin
                        @(negedge clk_put);
                        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                        put_req  = lf[0] | lf[1];
                        put_data = lf[11:4];
                        if (put_req && !put_full) begin
                            model[wr_i] = put_data;
                            wr_i++;
                        end
                    end
                    @(negedge clk_put);
                    put_req = 0;
                end
                begin
                    logic [15:0] lg = 16'h1D2B ^ 16'(gh * 7);
                    while (rd_i < NW) begin
                        @(negedge clk_get);
                        lg = {lg[14:0], lg[15] ^ lg[13] ^ lg[12] ^ lg[10]};
                        get_req = lg[2] | lg[5];
                        if (get_req && !get_empty) begin
                            chk(get_data == model[rd_i], "R9 stream data",
                                get_data, model[rd_i]);
                            rd_i++;
                        end
                        chk(wr_i - rd_i <= DEPTH, "R9 occupancy", wr_i - rd_i, DEPTH);
                    end
                    @(negedge clk_get);
                    get_req = 0;
                end
            join
            repeat (6) @(negedge clk_get);
            chk(get_empty == 1, "R9 drained", get_empty, 1);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule